// File: doc/BRIEF.md
# Host-Driven Configuration Load Port

This block lets a host processor push a configuration bitstream into a configuration engine over a simple parallel bus. The bus uses chip-select, read, write, a 2-bit address and a data word. The host opens a load session by setting the program bit in the control register and then clearing it. After that, each time the acknowledge register reads high, the host writes one bitstream word of 8, 16 or 32 bits to the data register. The port passes each accepted word to the engine over a valid/ready stream. The acknowledge stays low until the engine takes the word.

When the engine reports that this device's own bitstream is complete, the port can pass further words to devices chained behind it. With chaining enabled, those words go out MSB first on a serial data line, paced by a configuration clock. Bitstream faults are reported in a 2-bit status field. That field can be polled, and it can also drive a level interrupt that is cleared by reading status. A done output tells the rest of the chip that the load finished cleanly.

Top module: `cfg_host_port`

## Requirements
- R1: After reset, `irq`, `cfg_done`, `cfg_reset`, `stream_valid` and `daisy_cclk` are 0, the status register reads 0 and the acknowledge register reads 0.
- R2: A control write (address 0) with bit 0 = 1 drives `cfg_reset` high and clears the error field, the overrun flag and done. A later control write with bit 0 = 0 opens the session: `cfg_reset` falls and acknowledge (address 2, bit 0) reads 1.
- R3: An accepted data write (address 3) makes acknowledge read 0 from the next cycle on. Acknowledge returns to 1 on the clock edge where `stream_valid` and `stream_ready` are both high.
- R4: Control bits [4:3] select the word size: 00 = 8 bits, 01 = 16 bits, 10 or 11 = 32 bits. `stream_data` carries the low bits of the written word, zero-extended. `stream_width` shows the code, with 11 reported as 10.
- R5: While `stream_valid` is high and `stream_ready` is low, `stream_valid` stays high and `stream_data` does not change.
- R6: A data write while acknowledge reads 0 is dropped: nothing reaches the stream and the pending word is unchanged. It also sets the overrun flag (status bit 2), which stays set until the next program pulse.
- R7: Status bits [1:0] hold the bitstream error: 00 none, 01 framing/alignment, 10 CRC, 11 data after done. An engine report (`eng_err_valid` with a nonzero `eng_err_code`) is captured only while the field is 00. The first error therefore sticks.
- R8: With chaining off (control bit 1 = 0), a data write accepted after done sets error 11, clears done and is not forwarded.
- R9: With chaining on (control bit 1 = 1) and done set, an accepted word goes out MSB first on `daisy_dout`. Each bit takes 2 cycles and is valid while `daisy_cclk` is high. Acknowledge returns to 1 after the last bit.
- R10: With control bit 2 = 1, capturing an error raises `irq`. It stays high until a status read (address 1). With bit 2 = 0, an error does not raise `irq`.
- R11: `eng_done` sets `cfg_done` (status bit 3) only while the error field is 00. Capturing an error clears it, and so does a program pulse.
- R12: The control register reads back at address 0. Address 3 reads 0. Writes to addresses 1 and 2 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs | input | 1 | Chip select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational, 0 when not reading) |
| irq | output | 1 | Level interrupt on a bitstream error |
| cfg_done | output | 1 | Load completed with no error |
| cfg_reset | output | 1 | Engine reset, high while the program bit is set |
| stream_valid | output | 1 | Word available to the engine |
| stream_ready | input | 1 | Engine accepts the word |
| stream_data | output | DATA_W | Word to the engine, zero-extended |
| stream_width | output | 2 | Word size code: 0 = 8, 1 = 16, 2 = 32 bits |
| eng_err_valid | input | 1 | Engine reports an error |
| eng_err_code | input | 2 | Error code reported by the engine |
| eng_done | input | 1 | Engine finished this device's bitstream |
| daisy_dout | output | 1 | Serial data to chained devices |
| daisy_cclk | output | 1 | Serial clock to chained devices |

## Verification
Words are written at all three size codes, including the reserved code. The patterns have distinct bytes in every lane, so truncation, zero-extension and lane order can each be told apart. The stream is run both with the engine stalling and with it always ready. The stalled case separates the acknowledge handshake and the hold of the pending word from a simple one-cycle pulse. Serial forwarding is tried with an asymmetric byte and an asymmetric halfword, which exposes bit-order and bit-count mistakes. Engine errors are injected back to back, and a late data write is made with chaining off. Together these show which error wins and how done and the interrupt react.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

   typedef enum logic [1:0] {
      ERR_NONE  = 2'b00,
      ERR_FRAME = 2'b01,
      ERR_CRC   = 2'b10,
      ERR_LATE  = 2'b11
   } cfg_err_e;

   localparam logic [1:0] ADR_CTRL = 2'd0;
   localparam logic [1:0] ADR_STAT = 2'd1;
   localparam logic [1:0] ADR_ACK  = 2'd2;
   localparam logic [1:0] ADR_DATA = 2'd3;

   // control register image, bit 0 at the bottom
   typedef struct packed {
      logic [1:0] width;
      logic       irq_en;
      logic       chain;
      logic       prog;
   } cfg_ctrl_t;

   function automatic logic [1:0] norm_width(input logic [1:0] code);
      return (code == 2'b11) ? 2'b10 : code;
   endfunction

endpackage

// File: rtl/cfg_regs.sv
module cfg_regs
   import cfg_port_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter bit CHAIN_IMPL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              rd,
   input  logic              wr,
   input  logic [1:0]        addr,
   input  logic [4:0]        ctrl_wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              ack_in,
   input  logic              eng_err_valid,
   input  logic [1:0]        eng_err_code,
   input  logic              eng_done,
   output logic              clr,
   output logic              fwd_stream,
   output logic              fwd_chain,
   output logic              armed,
   output logic [1:0]        width_code,
   output logic              prog,
   output logic              done,
   output logic              irq
);

   cfg_ctrl_t ctrl_q;
   cfg_err_e  err_q, err_new;
   logic      overrun_q, done_q, armed_q, irq_q;
   logic      ctrl_wr, data_wr, stat_rd, arm_evt, accept, late, err_set;

   assign ctrl_wr = cs & wr & (addr == ADR_CTRL);
   assign data_wr = cs & wr & (addr == ADR_DATA);
   assign stat_rd = cs & rd & (addr == ADR_STAT);
   assign clr     = ctrl_wr & ctrl_wdata[0];
   assign arm_evt = ctrl_wr & ~ctrl_wdata[0] & ctrl_q.prog;
   assign accept  = data_wr & ack_in;
   assign late    = accept & done_q & ~ctrl_q.chain;

   always_comb begin
      err_new = ERR_NONE;
      if (late)
         err_new = ERR_LATE;
      else if (eng_err_valid && armed_q)
         err_new = cfg_err_e'(eng_err_code);
   end
   assign err_set = (err_q == ERR_NONE) && (err_new != ERR_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         err_q     <= ERR_NONE;
         overrun_q <= 1'b0;
         done_q    <= 1'b0;
         armed_q   <= 1'b0;
         irq_q     <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            ctrl_q.prog   <= ctrl_wdata[0];
            ctrl_q.chain  <= ctrl_wdata[1] & CHAIN_IMPL;
            ctrl_q.irq_en <= ctrl_wdata[2];
            ctrl_q.width  <= ctrl_wdata[4:3];
         end
         if (clr) begin
            err_q     <= ERR_NONE;
            overrun_q <= 1'b0;
            done_q    <= 1'b0;
            armed_q   <= 1'b0;
            irq_q     <= 1'b0;
         end else begin
            if (arm_evt) armed_q <= 1'b1;
            if (err_set) err_q <= err_new;
            if (data_wr && !ack_in) overrun_q <= 1'b1;
            if (err_set) done_q <= 1'b0;
            else if (eng_done && armed_q && err_q == ERR_NONE) done_q <= 1'b1;
            if (err_set && ctrl_q.irq_en) irq_q <= 1'b1;
            else if (stat_rd) irq_q <= 1'b0;
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (cs && rd) begin
         unique case (addr)
            ADR_CTRL: rdata[4:0] = ctrl_q;
            ADR_STAT: rdata[4:0] = {armed_q, done_q, overrun_q, err_q};
            ADR_ACK:  rdata[0]   = ack_in;
            default:  rdata      = '0;
         endcase
      end
   end

   assign fwd_stream = accept & ~done_q;
   assign fwd_chain  = accept & done_q & ctrl_q.chain;
   assign armed      = armed_q;
   assign width_code = ctrl_q.width;
   assign prog       = ctrl_q.prog;
   assign done       = done_q;
   assign irq        = irq_q;

   // R7: a captured error holds until the next program pulse
   a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q != ERR_NONE && !clr) |=> (err_q == $past(err_q)));
   // R11: done never coexists with an error
   a_r11_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (err_q == ERR_NONE));
   // R10: interrupt only rises together with a captured error
   a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> (err_q != ERR_NONE));
   // R6: a rejected data write leaves the overrun flag set
   a_r6_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !ack_in) |=> overrun_q);

endmodule

// File: rtl/cfg_xfer.sv
module cfg_xfer
   import cfg_port_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              fwd_stream,
   input  logic              fwd_chain,
   input  logic [DATA_W-1:0] wdata,
   input  logic [1:0]        width_code,
   input  logic              stream_ready,
   input  logic              ser_done,
   output logic              pending,
   output logic              stream_valid,
   output logic [DATA_W-1:0] stream_data,
   output logic [1:0]        stream_width
);

   logic              valid_q, pend_q;
   logic [DATA_W-1:0] data_q, masked;
   logic [1:0]        width_q;
   logic              hs;

   always_comb begin
      unique case (norm_width(width_code))
         2'b00:   masked = DATA_W'(wdata[7:0]);
         2'b01:   masked = DATA_W'(wdata[15:0]);
         default: masked = DATA_W'(wdata[31:0]);
      endcase
   end

   assign hs = valid_q & stream_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         pend_q  <= 1'b0;
         data_q  <= '0;
         width_q <= '0;
      end else if (clr) begin
         valid_q <= 1'b0;
         pend_q  <= 1'b0;
      end else begin
         if (fwd_stream) begin
            valid_q <= 1'b1;
            data_q  <= masked;
            width_q <= norm_width(width_code);
         end else if (hs) begin
            valid_q <= 1'b0;
         end
         if (fwd_stream || fwd_chain) pend_q <= 1'b1;
         else if (hs || ser_done)     pend_q <= 1'b0;
      end
   end

   assign pending      = pend_q;
   assign stream_valid = valid_q;
   assign stream_data  = data_q;
   assign stream_width = width_q;

   // R5: a stalled word is held unchanged
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !stream_ready && !clr) |=> (valid_q && $stable(data_q)));
   // R3: an accepted write leaves a word pending on the next cycle
   a_r3_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_stream || fwd_chain) |=> pend_q);

endmodule

// File: rtl/cfg_chain_ser.sv
module cfg_chain_ser
   import cfg_port_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              start,
   input  logic [DATA_W-1:0] data,
   input  logic [1:0]        width_code,
   output logic              dout,
   output logic              cclk,
   output logic              fin
);

   localparam int CNT_W = $clog2(DATA_W + 1);

   logic              busy_q, phase_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] sh_q;

   assign fin = busy_q & phase_q & (cnt_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         phase_q <= 1'b0;
         cnt_q   <= '0;
         sh_q    <= '0;
      end else if (clr) begin
         busy_q  <= 1'b0;
         phase_q <= 1'b0;
      end else if (start) begin
         busy_q  <= 1'b1;
         phase_q <= 1'b0;
         unique case (norm_width(width_code))
            2'b00: begin sh_q <= data << (DATA_W - 8);  cnt_q <= CNT_W'(8);  end
            2'b01: begin sh_q <= data << (DATA_W - 16); cnt_q <= CNT_W'(16); end
            default: begin sh_q <= data << (DATA_W - 32); cnt_q <= CNT_W'(32); end
         endcase
      end else if (busy_q) begin
         phase_q <= ~phase_q;
         if (phase_q) begin
            sh_q  <= sh_q << 1;
            cnt_q <= cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
         end
      end
   end

   assign dout = busy_q & sh_q[DATA_W-1];
   assign cclk = busy_q & phase_q;

   // R9: every clock high phase is followed by a low phase
   a_r9_cclk_gap: assert property (@(posedge clk) disable iff (!rst_n)
      cclk |=> !cclk);
   // R9: data holds across the rising clock phase
   a_r9_dout_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !phase_q && !clr && !start) |=> $stable(dout));

endmodule

// File: rtl/cfg_host_port.sv
module cfg_host_port
   import cfg_port_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter bit CHAIN_IMPL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_cs,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   output logic              cfg_done,
   output logic              cfg_reset,
   output logic              stream_valid,
   input  logic              stream_ready,
   output logic [DATA_W-1:0] stream_data,
   output logic [1:0]        stream_width,
   input  logic              eng_err_valid,
   input  logic [1:0]        eng_err_code,
   input  logic              eng_done,
   output logic              daisy_dout,
   output logic              daisy_cclk
);

   if (DATA_W < 32 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("cfg_host_port: DATA_W must be a multiple of 8 and at least 32");
   end

   logic       clr, fwd_stream, fwd_chain, armed, pending, ack, ser_done, prog;
   logic [1:0] width_code;

   assign ack       = armed & ~pending;
   assign cfg_reset = prog;

   cfg_regs #(.DATA_W(DATA_W), .CHAIN_IMPL(CHAIN_IMPL)) u_regs (
      .clk, .rst_n, .cs(bus_cs), .rd(bus_rd), .wr(bus_wr), .addr(bus_addr),
      .ctrl_wdata(bus_wdata[4:0]), .rdata(bus_rdata), .ack_in(ack),
      .eng_err_valid, .eng_err_code, .eng_done,
      .clr, .fwd_stream, .fwd_chain, .armed, .width_code, .prog,
      .done(cfg_done), .irq
   );

   cfg_xfer #(.DATA_W(DATA_W)) u_xfer (
      .clk, .rst_n, .clr, .fwd_stream, .fwd_chain, .wdata(bus_wdata),
      .width_code, .stream_ready, .ser_done, .pending,
      .stream_valid, .stream_data, .stream_width
   );

   if (CHAIN_IMPL) begin : g_chain
      cfg_chain_ser #(.DATA_W(DATA_W)) u_ser (
         .clk, .rst_n, .clr, .start(fwd_chain), .data(bus_wdata),
         .width_code, .dout(daisy_dout), .cclk(daisy_cclk), .fin(ser_done)
      );
   end else begin : g_no_chain
      assign daisy_dout = 1'b0;
      assign daisy_cclk = 1'b0;
      assign ser_done   = 1'b0;
   end

   // R4: the stream never reports the reserved size code
   a_r4_width_legal: assert property (@(posedge clk) disable iff (!rst_n)
      stream_valid |-> (stream_width != 2'b11));

endmodule

// File: tb/cfg_host_port_tb_top.sv
module cfg_host_port_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_cs = 0, bus_rd = 0, bus_wr = 0;
   logic [1:0]  bus_addr = 0;
   logic [31:0] bus_wdata = 0;
   logic [31:0] bus_rdata;
   logic        irq, cfg_done, cfg_reset, stream_valid;
   logic        stream_ready = 0;
   logic [31:0] stream_data;
   logic [1:0]  stream_width;
   logic        eng_err_valid = 0;
   logic [1:0]  eng_err_code = 0;
   logic        eng_done = 0;
   logic        daisy_dout, daisy_cclk;

   int tests = 0;
   int fails = 0;

   always #5 clk = ~clk;

   cfg_host_port dut_i (
      .clk, .rst_n, .bus_cs, .bus_rd, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
      .irq, .cfg_done, .cfg_reset, .stream_valid, .stream_ready, .stream_data,
      .stream_width, .eng_err_valid, .eng_err_code, .eng_done, .daisy_dout, .daisy_cclk
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_cs = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_cs = 0; bus_wr = 0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_cs = 1; bus_rd = 1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_cs = 0; bus_rd = 0;
   endtask

   task automatic program_port(input logic [31:0] bits);
      logic [31:0] v;
      wr(2'd0, bits | 32'h1);
      chk("R2 cfg_reset high", {31'b0, cfg_reset}, 32'h1);
      wr(2'd0, bits & ~32'h1);
      chk("R2 cfg_reset low", {31'b0, cfg_reset}, 32'h0);
      rd(2'd2, v);
      chk("R2 ack after program", v, 32'h1);
   endtask

   task automatic pulse_err(input logic [1:0] code);
      @(negedge clk); eng_err_valid = 1; eng_err_code = code;
      @(negedge clk); eng_err_valid = 0; eng_err_code = 0;
   endtask

   task automatic pulse_done();
      @(negedge clk); eng_done = 1;
      @(negedge clk); eng_done = 0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      chk("R1 irq", {31'b0, irq}, 0);
      chk("R1 done", {31'b0, cfg_done}, 0);
      chk("R1 cfg_reset", {31'b0, cfg_reset}, 0);
      chk("R1 stream_valid", {31'b0, stream_valid}, 0);
      chk("R1 cclk", {31'b0, daisy_cclk}, 0);
      rd(2'd1, v); chk("R1 status", v, 0);
      rd(2'd2, v); chk("R1 ack", v, 0);
   endtask

   task automatic t_stall_8();
      logic [31:0] v;
      stream_ready = 0;
      program_port(32'h0);
      wr(2'd3, 32'hA5C3_1234);
      chk("R3 valid", {31'b0, stream_valid}, 1);
      chk("R4 8-bit data", stream_data, 32'h34);
      chk("R4 8-bit width", {30'b0, stream_width}, 0);
      rd(2'd2, v); chk("R3 ack low", v, 0);
      wr(2'd3, 32'hFFFF_FFFF);
      chk("R6 data kept", stream_data, 32'h34);
      chk("R5 still valid", {31'b0, stream_valid}, 1);
      stream_ready = 1;
      @(negedge clk);
      chk("R3 handshake done", {31'b0, stream_valid}, 0);
      rd(2'd2, v); chk("R3 ack back", v, 1);
      rd(2'd1, v); chk("R6 overrun flag", v, 32'h14);
      program_port(32'h0);
      rd(2'd1, v); chk("R2 overrun cleared", v, 32'h10);
   endtask

   task automatic t_width(input logic [1:0] code, input logic [31:0] d,
                          input logic [31:0] exp_d, input logic [1:0] exp_w);
      logic [31:0] v;
      stream_ready = 1;
      program_port({27'b0, code, 3'b000});
      wr(2'd3, d);
      chk("R4 data", stream_data, exp_d);
      chk("R4 width", {30'b0, stream_width}, {30'b0, exp_w});
      @(negedge clk);
      chk("R3 consumed", {31'b0, stream_valid}, 0);
      rd(2'd2, v); chk("R3 ack restored", v, 1);
   endtask

   task automatic t_errors();
      logic [31:0] v;
      program_port(32'h4);
      pulse_err(2'b10);
      chk("R10 irq raised", {31'b0, irq}, 1);
      pulse_err(2'b01);
      rd(2'd1, v); chk("R7 first error kept", v & 32'h3, 32'h2);
      chk("R10 irq cleared by status read", {31'b0, irq}, 0);
      pulse_done();
      chk("R11 no done with error", {31'b0, cfg_done}, 0);
      program_port(32'h0);
      rd(2'd1, v); chk("R2 error cleared", v, 32'h10);
   endtask

   task automatic t_late();
      logic [31:0] v;
      stream_ready = 1;
      program_port(32'h0);
      pulse_done();
      chk("R11 done set", {31'b0, cfg_done}, 1);
      rd(2'd1, v); chk("R11 status done", v, 32'h18);
      wr(2'd3, 32'h77);
      chk("R8 not forwarded", {31'b0, stream_valid}, 0);
      chk("R8 done cleared", {31'b0, cfg_done}, 0);
      chk("R10 no irq when disabled", {31'b0, irq}, 0);
      rd(2'd1, v); chk("R8 late error code", v & 32'h3, 32'h3);
   endtask

   task automatic t_chain(input logic [1:0] code, input int nb, input logic [31:0] d);
      logic [31:0] v, got;
      int n;
      program_port({27'b0, code, 3'b010});
      pulse_done();
      wr(2'd3, d);
      got = 0; n = 0;
      for (int i = 0; i < 4 * nb + 8 && n < nb; i++) begin
         if (stream_valid) chk("R9 stream untouched", 1, 0);
         if (daisy_cclk) begin got = {got[30:0], daisy_dout}; n++; end
         @(negedge clk);
      end
      chk("R9 bit count", n, nb);
      chk("R9 serial word", got, d);
      @(negedge clk);
      rd(2'd2, v); chk("R9 ack after last bit", v, 1);
   endtask

   task automatic t_map();
      logic [31:0] v, s;
      wr(2'd0, 32'h0E);
      rd(2'd0, v); chk("R12 control readback", v, 32'h0E);
      rd(2'd1, s);
      wr(2'd1, 32'h1F);
      wr(2'd2, 32'h0);
      rd(2'd1, v); chk("R12 status write ignored", v, s);
      rd(2'd3, v); chk("R12 data reads zero", v, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_stall_8();
      t_width(2'b01, 32'hDEAD_5A3C, 32'h5A3C, 2'b01);
      t_width(2'b10, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 2'b10);
      t_width(2'b11, 32'h8123_4567, 32'h8123_4567, 2'b10);
      t_errors();
      t_late();
      t_chain(2'b00, 8, 32'hB6);
      t_chain(2'b01, 16, 32'h5A3C);
      t_map();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule